// File: doc/BRIEF.md
# PAL Sync Line Sequencer

This block feeds the reload (period) and compare (pulse-width) registers of a double-buffered PWM timer so that the timer's output becomes a composite PAL sync waveform. The timer pulls its output low at every wrap and releases it when the count reaches the compare value. The sequencer keeps a position within one field, looks up the length and sync-pulse width of every entry, and hands them to the timer.

A field is held as a table of entries. The vertical-sync region is split into half-line entries: equalising half-lines with a short pulse and broad half-lines with a long pulse. Each half-line has its own period and pulse. All other entries are full lines with a normal horizontal sync. The timer only adopts new register values at a wrap. For that reason, the values for the entry after the current one are written a fixed number of cycles after each wrap, during the entry that comes before them. Every wrap also raises a one-cycle line-start pulse and presents the new entry number, so that a pixel fetcher can begin its transfer for that line.

Top module: `sync_line_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, line_idx_o is 0, wr_o and line_start_o are 0, and period_o/pulse_o hold the values of entry 0 (511 and 38 with default parameters).
- R2: A wrap_i high at a rising edge makes line_start_o high for exactly the following cycle and advances line_idx_o by one in that same cycle; with wrap_i low the index holds and no line start occurs.
- R3: A wrap taken while line_idx_o is the last entry (319 by default, N_ENT-1) returns line_idx_o to 0.
- R4: wr_o is a one-cycle strobe raised in the cycle that follows the WR_DELAY-th rising edge (8 by default) after the edge that sampled a wrap, or after the first edge following reset release.
- R5: At each strobe, period_o and pulse_o carry the values of the entry that follows line_idx_o; period_o is the entry length in clock cycles minus one, pulse_o is the low-time in cycles.
- R6: Entries 0-4 and 10-14 are equalising half-lines: period_o 511 (512 cycles), pulse_o 38.
- R7: Entries 5-9 are broad half-lines: period_o 511, pulse_o 437.
- R8: Entries 15-319 are full lines: period_o 1023 (1024 cycles), pulse_o 75.
- R9: The strobe issued during the last entry stages the values of entry 0.
- R10: When a wrap is sampled on the same edge that issues a pending strobe, that strobe still carries the values of the entry after the old line, and a new strobe follows WR_DELAY edges later with the values of the entry after the new line.
- R11: Without a wrap, no further strobe occurs after a write, and period_o and pulse_o stay unchanged between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wrap_i | input | 1 | One-cycle pulse from the timer at each counter wrap (update event) |
| period_o | output | 10 | Reload value for the timer: entry length minus one |
| pulse_o | output | 10 | Compare value for the timer: sync low-time in cycles |
| wr_o | output | 1 | One-cycle strobe that writes period_o and pulse_o into the timer's preload registers |
| line_start_o | output | 1 | One-cycle pulse at the start of each entry, used to start the line's data transfer |
| line_idx_o | output | 9 | Entry currently being produced by the timer |

## Verification
The wrap that advances the line and the delayed write of the staged values can land on the same clock edge. When that happens, the write must use the entry that was current before the wrap, and a fresh write must then be armed for the new entry. The bench provokes this by spacing wraps exactly WR_DELAY cycles apart over several consecutive entries. The scoreboard then expects one strobe on the coinciding edge with the old line's successor values, and one more strobe WR_DELAY edges later with the new line's successor values. Any merged, dropped or misattributed strobe appears as a timing or value mismatch.

// File: rtl/sls_pkg.sv
// Shared types and constant functions for the PAL sync line sequencer.
// Assumes a field ordered as: pre-equalising half-lines, broad half-lines,
// post-equalising half-lines, then full lines.
package sls_pkg;

    typedef enum logic [1:0] {
        SEG_EQUAL = 2'd0,
        SEG_BROAD = 2'd1,
        SEG_FULL  = 2'd2
    } seg_kind_e;

    // Classify an entry number into its segment kind.
    function automatic seg_kind_e seg_kind(input int unsigned idx,
                                           input int unsigned n_pre,
                                           input int unsigned n_broad,
                                           input int unsigned n_post);
        if (idx < n_pre)                         return SEG_EQUAL;
        else if (idx < n_pre + n_broad)          return SEG_BROAD;
        else if (idx < n_pre + n_broad + n_post) return SEG_EQUAL;
        else                                     return SEG_FULL;
    endfunction

    // Length of an entry in clock cycles.
    function automatic int unsigned seg_len(input seg_kind_e k,
                                            input int unsigned line_cyc);
        return (k == SEG_FULL) ? line_cyc : line_cyc / 2;
    endfunction

    // Sync low-time of an entry in clock cycles.
    function automatic int unsigned seg_pulse(input seg_kind_e k,
                                              input int unsigned eq_cyc,
                                              input int unsigned broad_cyc,
                                              input int unsigned hs_cyc);
        case (k)
            SEG_EQUAL: return eq_cyc;
            SEG_BROAD: return broad_cyc;
            default:   return hs_cyc;
        endcase
    endfunction

endpackage

// File: rtl/sls_line_ctr.sv
// Entry counter for one field. Advances on each timer wrap, wraps from the
// last entry to zero, and emits a registered line-start pulse.
// Assumes wrap_i is a single-cycle pulse.
module sls_line_ctr #(
    parameter int unsigned N_ENT = 320,
    parameter int unsigned IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [IDX_W-1:0] nxt_o,
    output logic             start_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENT - 1);

    logic [IDX_W-1:0] idx_q;
    logic             start_q;

    // Successor entry, wrapping at the end of the field.
    always_comb begin
        nxt_o = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end

    // Advance the entry and flag a line start on each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= wrap_i;
            if (wrap_i) begin
                idx_q <= nxt_o;
            end
        end
    end

    assign idx_o   = idx_q;
    assign start_o = start_q;

endmodule

// File: rtl/sls_wr_sched.sv
// Write scheduler: after each wrap (and after reset) counts WR_DELAY edges,
// then asserts fire_o for one cycle. A wrap re-arms the count; a wrap on the
// firing edge does not suppress that firing.
// Assumes WR_DELAY >= 1 and shorter than the shortest entry.
module sls_wr_sched #(
    parameter int unsigned WR_DELAY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    output logic fire_o
);
    localparam int unsigned DLY_W = $clog2(WR_DELAY + 1);
    localparam logic [DLY_W-1:0] LAST_CNT = DLY_W'(WR_DELAY - 1);

    logic             pend_q;
    logic [DLY_W-1:0] cnt_q;

    // Fire when the delay count completes while a write is pending.
    always_comb begin
        fire_o = pend_q && (cnt_q == LAST_CNT);
    end

    // Arm on wrap or reset, count while armed, disarm after firing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b1;
            cnt_q  <= '0;
        end else if (wrap_i) begin
            pend_q <= 1'b1;
            cnt_q  <= '0;
        end else if (fire_o) begin
            pend_q <= 1'b0;
        end else if (pend_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sls_seg_lookup.sv
// Combinational lookup of reload and compare values for one entry number.
// The period is given as length minus one, the form a reload register takes.
module sls_seg_lookup
    import sls_pkg::*;
#(
    parameter int unsigned LINE_CYC  = 1024,
    parameter int unsigned HSYNC_CYC = 75,
    parameter int unsigned EQ_CYC    = 38,
    parameter int unsigned BROAD_CYC = 437,
    parameter int unsigned N_EQ_PRE  = 5,
    parameter int unsigned N_BROAD   = 5,
    parameter int unsigned N_EQ_POST = 5,
    parameter int unsigned IDX_W     = 9,
    parameter int unsigned CYC_W     = 10
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [CYC_W-1:0] period_o,
    output logic [CYC_W-1:0] pulse_o
);
    seg_kind_e kind;

    // Decode the segment kind, then its length and pulse.
    always_comb begin
        kind     = seg_kind(int'(idx_i), N_EQ_PRE, N_BROAD, N_EQ_POST);
        period_o = CYC_W'(seg_len(kind, LINE_CYC) - 1);
        pulse_o  = CYC_W'(seg_pulse(kind, EQ_CYC, BROAD_CYC, HSYNC_CYC));
    end

endmodule

// File: rtl/sync_line_seq.sv
// PAL sync line sequencer top. Tracks the entry the timer is producing and,
// a fixed delay after every wrap, writes the next entry's reload and compare
// values into the timer's preload registers. Reset values are those of
// entry 0 so the timer can be loaded before its first wrap.
module sync_line_seq
    import sls_pkg::*;
#(
    parameter int unsigned LINE_CYC  = 1024,
    parameter int unsigned HSYNC_CYC = 75,
    parameter int unsigned EQ_CYC    = 38,
    parameter int unsigned BROAD_CYC = 437,
    parameter int unsigned N_EQ_PRE  = 5,
    parameter int unsigned N_BROAD   = 5,
    parameter int unsigned N_EQ_POST = 5,
    parameter int unsigned N_FULL    = 305,
    parameter int unsigned WR_DELAY  = 8,
    localparam int unsigned N_ENT    = N_EQ_PRE + N_BROAD + N_EQ_POST + N_FULL,
    localparam int unsigned IDX_W    = $clog2(N_ENT),
    localparam int unsigned CYC_W    = $clog2(LINE_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap_i,
    output logic [CYC_W-1:0] period_o,
    output logic [CYC_W-1:0] pulse_o,
    output logic             wr_o,
    output logic             line_start_o,
    output logic [IDX_W-1:0] line_idx_o
);
    localparam seg_kind_e   KIND0   = seg_kind(0, N_EQ_PRE, N_BROAD, N_EQ_POST);
    localparam int unsigned RST_PER = seg_len(KIND0, LINE_CYC) - 1;
    localparam int unsigned RST_PUL = seg_pulse(KIND0, EQ_CYC, BROAD_CYC, HSYNC_CYC);

    logic [IDX_W-1:0] nxt_idx;
    logic [CYC_W-1:0] lk_period;
    logic [CYC_W-1:0] lk_pulse;
    logic             fire;
    logic [CYC_W-1:0] period_q;
    logic [CYC_W-1:0] pulse_q;
    logic             wr_q;

    sls_line_ctr #(
        .N_ENT (N_ENT),
        .IDX_W (IDX_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap_i  (wrap_i),
        .idx_o   (line_idx_o),
        .nxt_o   (nxt_idx),
        .start_o (line_start_o)
    );

    sls_wr_sched #(
        .WR_DELAY (WR_DELAY)
    ) u_sched (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap_i (wrap_i),
        .fire_o (fire)
    );

    sls_seg_lookup #(
        .LINE_CYC  (LINE_CYC),
        .HSYNC_CYC (HSYNC_CYC),
        .EQ_CYC    (EQ_CYC),
        .BROAD_CYC (BROAD_CYC),
        .N_EQ_PRE  (N_EQ_PRE),
        .N_BROAD   (N_BROAD),
        .N_EQ_POST (N_EQ_POST),
        .IDX_W     (IDX_W),
        .CYC_W     (CYC_W)
    ) u_lookup (
        .idx_i    (nxt_idx),
        .period_o (lk_period),
        .pulse_o  (lk_pulse)
    );

    // Capture the successor entry's values and strobe them out when due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= CYC_W'(RST_PER);
            pulse_q  <= CYC_W'(RST_PUL);
            wr_q     <= 1'b0;
        end else begin
            wr_q <= fire;
            if (fire) begin
                period_q <= lk_period;
                pulse_q  <= lk_pulse;
            end
        end
    end

    assign period_o = period_q;
    assign pulse_o  = pulse_q;
    assign wr_o     = wr_q;

endmodule

// File: rtl/sls_chk.sv
// Property checker for the sync line sequencer, bound to its top module.
// Keeps its own count of edges since the last wrap to judge strobe timing.
module sls_chk #(
    parameter int unsigned N_ENT    = 320,
    parameter int unsigned IDX_W    = 9,
    parameter int unsigned CYC_W    = 10,
    parameter int unsigned WR_DELAY = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wrap_i,
    input logic [CYC_W-1:0] period_o,
    input logic [CYC_W-1:0] pulse_o,
    input logic             wr_o,
    input logic             line_start_o,
    input logic [IDX_W-1:0] line_idx_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENT - 1);

    logic [15:0] since_q;

    // Edges since the last sampled wrap (or reset), saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_q <= 16'd1;
        else if (wrap_i)          since_q <= 16'd1;
        else if (since_q != 16'hFFFF) since_q <= since_q + 16'd1;
    end

    // R2
    start_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> line_start_o);

    // R2
    no_stray_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> (!line_start_o && $stable(line_idx_o)));

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && line_idx_o != LAST_IDX) |=>
            line_idx_o == IDX_W'($past(line_idx_o) + 1'b1));

    // R3
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && line_idx_o == LAST_IDX) |=> line_idx_o == '0);

    // R4
    strobe_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> $past(since_q) == 16'(WR_DELAY));

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> !wr_o);

    // R11
    hold_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_o |-> ($stable(period_o) && $stable(pulse_o)));

    // R6 R7 R8
    pulse_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> pulse_o < period_o);

endmodule

bind sync_line_seq sls_chk #(
    .N_ENT    (N_ENT),
    .IDX_W    (IDX_W),
    .CYC_W    (CYC_W),
    .WR_DELAY (WR_DELAY)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wrap_i       (wrap_i),
    .period_o     (period_o),
    .pulse_o      (pulse_o),
    .wr_o         (wr_o),
    .line_start_o (line_start_o),
    .line_idx_o   (line_idx_o)
);

// File: tb/tb_sync_line_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver issues wraps and queues the expected line
// starts and strobes; a monitor pops and compares them as they appear.
module tb_sync_line_seq;
    localparam int NE = 320;
    localparam int D  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wrap_i = 1'b0;
    logic [9:0] period_o;
    logic [9:0] pulse_o;
    logic       wr_o;
    logic       line_start_o;
    logic [8:0] line_idx_o;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int cur = 0;
    int last_per = 511;
    int last_pul = 38;

    typedef struct {
        int    at;
        int    a;
        int    b;
        string req;
    } exp_t;

    exp_t wr_q[$];
    exp_t ls_q[$];

    sync_line_seq dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wrap_i       (wrap_i),
        .period_o     (period_o),
        .pulse_o      (pulse_o),
        .wr_o         (wr_o),
        .line_start_o (line_start_o),
        .line_idx_o   (line_idx_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int e_per(input int i);
        return (i < 15) ? 511 : 1023;
    endfunction

    function automatic int e_pul(input int i);
        if (i < 5 || (i >= 10 && i < 15)) return 38;
        else if (i < 10) return 437;
        else return 75;
    endfunction

    function automatic string e_tag(input int i);
        if (i == 0) return "R9 R5";
        else if (i < 5 || (i >= 10 && i < 15)) return "R6 R5";
        else if (i < 10) return "R7 R5";
        else return "R8 R5";
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: one wrap after 'gap' idle negedges; queues what must follow.
    task automatic wrap_after(input int gap, input string tag);
        int nx;
        int st;
        repeat (gap) @(negedge clk);
        wrap_i = 1'b1;
        nx = (cur + 1) % NE;
        st = (nx + 1) % NE;
        ls_q.push_back('{cyc + 1, nx, 0, (nx == 0) ? "R3" : "R2"});
        wr_q.push_back('{cyc + 1 + D, e_per(st), e_pul(st),
                         (tag == "") ? e_tag(st) : tag});
        cur = nx;
        last_per = e_per(st);
        last_pul = e_pul(st);
        @(negedge clk);
        wrap_i = 1'b0;
    endtask

    // Monitor: compare strobes and line starts against the queues.
    always @(negedge clk) begin
        if (rst_n) begin
            while (wr_q.size() > 0 && wr_q[0].at < cyc) begin
                chk(1'b0, {wr_q[0].req, " missed strobe"}, 0, 1);
                void'(wr_q.pop_front());
            end
            while (ls_q.size() > 0 && ls_q[0].at < cyc) begin
                chk(1'b0, {ls_q[0].req, " missed line start"}, 0, 1);
                void'(ls_q.pop_front());
            end
            if (wr_o) begin
                if (wr_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = wr_q.pop_front();
                    chk(cyc == e.at, {e.req, " R4 strobe cycle"}, cyc, e.at);
                    chk(int'(period_o) == e.a, {e.req, " period"}, int'(period_o), e.a);
                    chk(int'(pulse_o) == e.b, {e.req, " pulse"}, int'(pulse_o), e.b);
                end
            end
            if (line_start_o) begin
                if (ls_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected line start", 1, 0);
                end else begin
                    exp_t e;
                    e = ls_q.pop_front();
                    chk(cyc == e.at, {e.req, " line start cycle"}, cyc, e.at);
                    chk(int'(line_idx_o) == e.a, {e.req, " line index"}, int'(line_idx_o), e.a);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cyc >= 150000);
        mismatched++;
        $display("FAIL watchdog: actual %0d expected below 150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(line_idx_o == 9'd0, "R1 index", int'(line_idx_o), 0);
        chk(period_o == 10'd511, "R1 period", int'(period_o), 511);
        chk(pulse_o == 10'd38, "R1 pulse", int'(pulse_o), 38);
        chk(!wr_o && !line_start_o, "R1 strobes", int'(wr_o) + int'(line_start_o), 0);
        rst_n = 1'b1;
        // R4: first strobe after reset stages entry 1
        wr_q.push_back('{cyc + D, e_per(1), e_pul(1), "R4 R6 R5"});
        last_per = e_per(1);
        last_pul = e_pul(1);
        @(negedge clk);
        chk(line_idx_o == 9'd0 && period_o == 10'd511, "R1 after release",
            int'(period_o), 511);
        repeat (15) @(negedge clk);

        // Walk a whole field: equalising, broad, full lines, then R9 and R3.
        for (int i = 0; i < NE; i++) wrap_after(11 + (i % 3), "");
        repeat (20) @(negedge clk);

        // R10: wraps landing on the same edge as the pending strobe.
        for (int i = 0; i < 6; i++) wrap_after(D - 1, "R10 R5");
        repeat (20) @(negedge clk);

        // R11: idle period, values hold and no strobe appears.
        repeat (60) @(negedge clk);
        chk(int'(period_o) == last_per, "R11 period held", int'(period_o), last_per);
        chk(int'(pulse_o) == last_pul, "R11 pulse held", int'(pulse_o), last_pul);

        // Continue into the vertical interval once more with mixed spacing.
        for (int i = 0; i < NE; i++) wrap_after((i % 5 == 0) ? D - 1 : 12, "");
        repeat (30) @(negedge clk);

        chk(wr_q.size() == 0, "R4 all strobes seen", wr_q.size(), 0);
        chk(ls_q.size() == 0, "R2 all line starts seen", ls_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule